// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit resolves the six-bit effective-address field of a 68000-style instruction into an operand location. The upper three bits of the field pick a mode group and the lower three pick a register. For the eight groups of the first seven rows and the eight special codes of the last row, the unit fetches whatever extension words the mode needs and reads the address registers and index registers it depends on. It then returns either a register index, for register-direct operands, or a 32-bit effective address. Alongside the result it returns the extra execution cycles the mode costs.

A sequencer pulses `start_i` with the field, the operand size, a write-intent flag and the PC of the first extension word. Extension words arrive over a request/valid port in stream order. The index value of the base register and the index register are read through two combinational read ports. When the result is ready the unit raises `done_o` for one cycle. In that same cycle it issues the single address-register update that the post-increment and pre-decrement modes call for. An illegal code or a write to a read-only mode is reported by a flag and does not stall the unit.

Top module: `ea_gen_unit`

## Requirements
- R1: Codes 0x00–0x0F fetch no extension word and finish with `reg_direct_o`=1, `reg_idx_o` = code[3:0] (0–7 data registers, 8–15 address registers), `ea_addr_o`=0 and zero extra cycles.
- R2: The size encoding is 0 byte, 1 word, 2 long, and 3 is treated as long. Code rows 2, 3 and 4 use An as the address for indirect, use An as the address for post-increment and then write back An+step, and, for pre-decrement, write back An−step and use it as the address. The step is 1/2/4 by size, except that a byte step on register 7 is 2. The write back goes to index 8+reg on `rf_we_o`.
- R3: Row 5 takes one extension word, sign-extends it from 16 bits and adds it to An.
- R4: Row 6 takes one brief word. Bits 15..12 name the index register (0–7 data, 8–15 address). Bit 11 set selects the full 32-bit index, and clear selects its sign-extended low half. Bits 7..0 are a signed displacement. The address is An + index + displacement.
- R5: Code 0x38 sign-extends one word to an absolute address. Code 0x39 takes two words, the first being bits 31..16.
- R6: Codes 0x3A and 0x3B use a base of `pc_i` (the PC of their extension word) with bits 23..0 kept and sign-extended from bit 23. Code 0x3A adds a sign-extended 16-bit word, and 0x3B applies the brief-word rule of R4.
- R7: Code 0x3C places the immediate on `ea_addr_o`. A byte takes one word with bits 7..0 sign-extended, a word takes one word sign-extended, and a long takes two words with the first being bits 31..16.
- R8: Codes 0x3D–0x3F set `illegal_o`, fetch nothing, report zero cycles and never assert `rf_we_o`.
- R9: The extra-cycle count is given in the form byte-or-word/long. Pre-decrement costs 6/10. The 16-bit displacement modes on An and on the PC cost 8/12. Both indexed modes cost 10/14. Absolute short costs 8/12 and absolute long costs 12/16. Immediate costs 4/8. Every other code costs 0.
- R10: `not_writable_o` is 1 exactly when `wr_intent_i` was set and the code is 0x3A, 0x3B or 0x3C.
- R11: `ext_req_o` stays high until a cycle with `ext_valid_i`. Each word is taken in stream order, and `pc_o` advances by 2 per word taken.
- R12: `done_o` is a one-cycle pulse, two cycles after the start edge plus one per word and per stalled request cycle. `rf_we_o` is only ever high together with `done_o`. After reset `done_o`, `ext_req_o` and `rf_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin resolving a field (taken when idle) |
| ea_code_i | input | 6 | Mode group [5:3], register [2:0] |
| op_size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| wr_intent_i | input | 1 | Operand will be written |
| pc_i | input | 32 | PC of the first extension word |
| ext_req_o | output | 1 | Extension word wanted |
| ext_valid_i | input | 1 | Extension word present |
| ext_word_i | input | 16 | Extension word |
| rf_base_idx_o | output | 4 | Base register read index (always an address register) |
| rf_base_data_i | input | 32 | Base register value |
| rf_index_idx_o | output | 4 | Index register read index |
| rf_index_data_i | input | 32 | Index register value |
| rf_we_o | output | 1 | Address register update strobe |
| rf_wr_idx_o | output | 4 | Updated register index |
| rf_wr_data_o | output | 32 | Updated register value |
| done_o | output | 1 | Result valid pulse |
| ea_addr_o | output | 32 | Effective address or immediate value |
| reg_direct_o | output | 1 | Operand is a register |
| reg_idx_o | output | 4 | Register index for register-direct operands |
| extra_cycles_o | output | 5 | Extra execution cycles for the mode |
| illegal_o | output | 1 | Code is not a valid mode |
| not_writable_o | output | 1 | Write intent on a read-only mode |
| pc_o | output | 32 | PC after the consumed extension words |

## Verification
With words supplied at once, a mode with n extension words raises `done_o` in the cycle after the (n+2)-th rising edge counted from the start edge. Each cycle in which a request is left without a valid word adds one cycle. The bench counts rising edges from the start edge and compares that count against n+2 plus the stalls it inserted. It samples the results at the falling edge in which `done_o` is seen. Each start pushes its expected result into a queue, and the monitor pops one entry per done pulse. Every falling edge is also checked for a register write outside a done pulse.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int CODE_W      = 6;
    localparam int EXT_W       = 16;
    localparam int RIDX_W      = 4;
    localparam int CYC_W       = 5;
    localparam int STEP_W      = 3;
    localparam int BRIEF_LBIT  = 11;
    localparam int BRIEF_DW    = 8;

    typedef enum logic [3:0] {
        EA_DREG, EA_AREG, EA_IND, EA_POSTINC, EA_PREDEC, EA_DISP,
        EA_INDEX, EA_ABSW, EA_ABSL, EA_PCDISP, EA_PCINDEX, EA_IMM,
        EA_BAD
    } ea_class_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } opsize_t;

    typedef struct packed {
        ea_class_t          cls;
        logic [1:0]         n_words;
        logic [CYC_W-1:0]   extra;
        logic [STEP_W-1:0]  step;
        logic               illegal;
        logic               no_write;
        logic               updates;
    } ea_decode_t;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  opsize_t           size_i,
    output ea_decode_t        info_o
);
    logic       is_long;
    logic [2:0] rsel;

    always_comb begin
        is_long = (size_i == SZ_LONG) || (size_i == SZ_RSVD);
        rsel    = code_i[2:0];

        info_o          = '0;
        info_o.cls      = EA_DREG;

        // step for post-increment / pre-decrement; byte on the stack register keeps alignment
        unique case (size_i)
            SZ_BYTE: info_o.step = (rsel == 3'd7) ? STEP_W'(2) : STEP_W'(1);
            SZ_WORD: info_o.step = STEP_W'(2);
            default: info_o.step = STEP_W'(4);
        endcase

        case (code_i[5:3])
            3'd0: info_o.cls = EA_DREG;
            3'd1: info_o.cls = EA_AREG;
            3'd2: info_o.cls = EA_IND;
            3'd3: begin
                info_o.cls     = EA_POSTINC;
                info_o.updates = 1'b1;
            end
            3'd4: begin
                info_o.cls     = EA_PREDEC;
                info_o.updates = 1'b1;
                info_o.extra   = is_long ? CYC_W'(10) : CYC_W'(6);
            end
            3'd5: begin
                info_o.cls     = EA_DISP;
                info_o.n_words = 2'd1;
                info_o.extra   = is_long ? CYC_W'(12) : CYC_W'(8);
            end
            3'd6: begin
                info_o.cls     = EA_INDEX;
                info_o.n_words = 2'd1;
                info_o.extra   = is_long ? CYC_W'(14) : CYC_W'(10);
            end
            default: begin
                case (rsel)
                    3'd0: begin
                        info_o.cls     = EA_ABSW;
                        info_o.n_words = 2'd1;
                        info_o.extra   = is_long ? CYC_W'(12) : CYC_W'(8);
                    end
                    3'd1: begin
                        info_o.cls     = EA_ABSL;
                        info_o.n_words = 2'd2;
                        info_o.extra   = is_long ? CYC_W'(16) : CYC_W'(12);
                    end
                    3'd2: begin
                        info_o.cls      = EA_PCDISP;
                        info_o.n_words  = 2'd1;
                        info_o.no_write = 1'b1;
                        info_o.extra    = is_long ? CYC_W'(12) : CYC_W'(8);
                    end
                    3'd3: begin
                        info_o.cls      = EA_PCINDEX;
                        info_o.n_words  = 2'd1;
                        info_o.no_write = 1'b1;
                        info_o.extra    = is_long ? CYC_W'(14) : CYC_W'(10);
                    end
                    3'd4: begin
                        info_o.cls      = EA_IMM;
                        info_o.n_words  = is_long ? 2'd2 : 2'd1;
                        info_o.no_write = 1'b1;
                        info_o.extra    = is_long ? CYC_W'(8) : CYC_W'(4);
                    end
                    default: begin
                        info_o.cls     = EA_BAD;
                        info_o.illegal = 1'b1;
                    end
                endcase
            end
        endcase
    end

    // illegal codes carry neither a cost nor a fetch (R8)
    always_comb begin
        if (info_o.illegal) begin
            assert_bad_is_free_R8: assert (info_o.n_words == 2'd0 && info_o.extra == '0 && !info_o.updates);
        end
    end

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int PC_KEEP = 24
) (
    input  ea_class_t          cls_i,
    input  opsize_t            size_i,
    input  logic [STEP_W-1:0]  step_i,
    input  logic [XLEN-1:0]    base_i,
    input  logic [XLEN-1:0]    index_i,
    input  logic [PC_KEEP-1:0] pc_low_i,
    input  logic [EXT_W-1:0]   ext0_i,
    input  logic [EXT_W-1:0]   ext1_i,
    output logic [XLEN-1:0]    addr_o,
    output logic [XLEN-1:0]    new_an_o
);
    logic [XLEN-1:0] step_x;
    logic [XLEN-1:0] disp_wide;
    logic [XLEN-1:0] disp_short;
    logic [XLEN-1:0] idx_val;
    logic [XLEN-1:0] pc_base;
    logic [XLEN-1:0] brief_off;
    logic [XLEN-1:0] imm_byte;
    logic [XLEN-1:0] pair;

    always_comb begin
        step_x     = XLEN'(step_i);
        disp_wide  = {{(XLEN-EXT_W){ext0_i[EXT_W-1]}}, ext0_i};
        disp_short = {{(XLEN-BRIEF_DW){ext0_i[BRIEF_DW-1]}}, ext0_i[BRIEF_DW-1:0]};
        imm_byte   = disp_short;
        idx_val    = ext0_i[BRIEF_LBIT] ? index_i
                                        : {{(XLEN-EXT_W){index_i[EXT_W-1]}}, index_i[EXT_W-1:0]};
        pc_base    = {{(XLEN-PC_KEEP){pc_low_i[PC_KEEP-1]}}, pc_low_i};
        brief_off  = idx_val + disp_short;
        pair       = XLEN'({ext0_i, ext1_i});

        new_an_o = base_i;
        addr_o   = '0;
        case (cls_i)
            EA_IND:     addr_o = base_i;
            EA_POSTINC: begin
                addr_o   = base_i;
                new_an_o = base_i + step_x;
            end
            EA_PREDEC:  begin
                new_an_o = base_i - step_x;
                addr_o   = base_i - step_x;
            end
            EA_DISP:    addr_o = base_i + disp_wide;
            EA_INDEX:   addr_o = base_i + brief_off;
            EA_ABSW:    addr_o = disp_wide;
            EA_ABSL:    addr_o = pair;
            EA_PCDISP:  addr_o = pc_base + disp_wide;
            EA_PCINDEX: addr_o = pc_base + brief_off;
            EA_IMM: begin
                unique case (size_i)
                    SZ_BYTE: addr_o = imm_byte;
                    SZ_WORD: addr_o = disp_wide;
                    default: addr_o = pair;
                endcase
            end
            default:    addr_o = '0;
        endcase
    end

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import ea_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int PC_KEEP = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [5:0]        ea_code_i,
    input  logic [1:0]        op_size_i,
    input  logic              wr_intent_i,
    input  logic [XLEN-1:0]   pc_i,
    output logic              ext_req_o,
    input  logic              ext_valid_i,
    input  logic [15:0]       ext_word_i,
    output logic [3:0]        rf_base_idx_o,
    input  logic [XLEN-1:0]   rf_base_data_i,
    output logic [3:0]        rf_index_idx_o,
    input  logic [XLEN-1:0]   rf_index_data_i,
    output logic              rf_we_o,
    output logic [3:0]        rf_wr_idx_o,
    output logic [XLEN-1:0]   rf_wr_data_o,
    output logic              done_o,
    output logic [XLEN-1:0]   ea_addr_o,
    output logic              reg_direct_o,
    output logic [3:0]        reg_idx_o,
    output logic [4:0]        extra_cycles_o,
    output logic              illegal_o,
    output logic              not_writable_o,
    output logic [XLEN-1:0]   pc_o
);

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_FINISH} state_t;

    typedef struct packed {
        state_t              st;
        logic [CODE_W-1:0]   code;
        opsize_t             size;
        logic                wr_intent;
        logic [XLEN-1:0]     pc;
        logic [PC_KEEP-1:0]  pc_first;
        logic [1:0]          left;
        logic                got;
        logic [EXT_W-1:0]    ext0;
        logic [EXT_W-1:0]    ext1;
        logic                done;
        logic [XLEN-1:0]     addr;
        logic                reg_dir;
        logic [RIDX_W-1:0]   ridx;
        logic [CYC_W-1:0]    extra;
        logic                illegal;
        logic                no_wr;
        logic                we;
        logic [RIDX_W-1:0]   widx;
        logic [XLEN-1:0]     wdata;
    } ctx_t;

    ctx_t cur_q, nxt_d;

    logic [CODE_W-1:0] dec_code;
    opsize_t           dec_size;
    ea_decode_t        dec;
    logic [XLEN-1:0]   calc_addr;
    logic [XLEN-1:0]   calc_an;

    // decode the incoming field while idle, the held field afterwards
    assign dec_code = (cur_q.st == ST_IDLE) ? ea_code_i : cur_q.code;
    assign dec_size = (cur_q.st == ST_IDLE) ? opsize_t'(op_size_i) : cur_q.size;

    ea_mode_decode u_decode (
        .code_i (dec_code),
        .size_i (dec_size),
        .info_o (dec)
    );

    ea_addr_calc #(
        .XLEN    (XLEN),
        .PC_KEEP (PC_KEEP)
    ) u_calc (
        .cls_i    (dec.cls),
        .size_i   (cur_q.size),
        .step_i   (dec.step),
        .base_i   (rf_base_data_i),
        .index_i  (rf_index_data_i),
        .pc_low_i (cur_q.pc_first),
        .ext0_i   (cur_q.ext0),
        .ext1_i   (cur_q.ext1),
        .addr_o   (calc_addr),
        .new_an_o (calc_an)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        nxt_d.we   = 1'b0;

        case (cur_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    nxt_d.code      = ea_code_i;
                    nxt_d.size      = opsize_t'(op_size_i);
                    nxt_d.wr_intent = wr_intent_i;
                    nxt_d.pc        = pc_i;
                    nxt_d.pc_first  = pc_i[PC_KEEP-1:0];
                    nxt_d.left      = dec.n_words;
                    nxt_d.got       = 1'b0;
                    nxt_d.ext0      = '0;
                    nxt_d.ext1      = '0;
                    nxt_d.st        = (dec.n_words != 2'd0) ? ST_FETCH : ST_FINISH;
                end
            end
            ST_FETCH: begin
                if (ext_valid_i) begin
                    if (!cur_q.got) nxt_d.ext0 = ext_word_i;
                    else            nxt_d.ext1 = ext_word_i;
                    nxt_d.got  = 1'b1;
                    nxt_d.pc   = cur_q.pc + XLEN'(2);
                    nxt_d.left = cur_q.left - 2'd1;
                    if (cur_q.left == 2'd1) nxt_d.st = ST_FINISH;
                end
            end
            ST_FINISH: begin
                nxt_d.done    = 1'b1;
                nxt_d.reg_dir = (dec.cls == EA_DREG) || (dec.cls == EA_AREG);
                nxt_d.ridx    = cur_q.code[RIDX_W-1:0];
                nxt_d.addr    = calc_addr;
                nxt_d.extra   = dec.extra;
                nxt_d.illegal = dec.illegal;
                nxt_d.no_wr   = cur_q.wr_intent && dec.no_write;
                nxt_d.we      = dec.updates && !dec.illegal;
                nxt_d.widx    = {1'b1, cur_q.code[2:0]};
                nxt_d.wdata   = calc_an;
                nxt_d.st      = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ext_req_o      = (cur_q.st == ST_FETCH);
    assign rf_base_idx_o  = {1'b1, cur_q.code[2:0]};
    assign rf_index_idx_o = cur_q.ext0[EXT_W-1 -: RIDX_W];
    assign rf_we_o        = cur_q.we;
    assign rf_wr_idx_o    = cur_q.widx;
    assign rf_wr_data_o   = cur_q.wdata;
    assign done_o         = cur_q.done;
    assign ea_addr_o      = cur_q.addr;
    assign reg_direct_o   = cur_q.reg_dir;
    assign reg_idx_o      = cur_q.ridx;
    assign extra_cycles_o = cur_q.extra;
    assign illegal_o      = cur_q.illegal;
    assign not_writable_o = cur_q.no_wr;
    assign pc_o           = cur_q.pc;

    // request held until a word is supplied (R11)
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_o && !ext_valid_i |=> ext_req_o);

    // each consumed word moves the PC by one word (R11)
    assert_pc_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_o && ext_valid_i |=> pc_o == $past(pc_o) + XLEN'(2));

    // register update only inside the done pulse (R12)
    assert_we_in_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> done_o);

    // done is a single-cycle pulse (R12)
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // illegal code: no update, no cost (R8)
    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && illegal_o |-> !rf_we_o && extra_cycles_o == '0);

    // updates only ever target an address register (R2)
    assert_upd_areg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> rf_wr_idx_o[RIDX_W-1]);

endmodule

// File: tb/ea_gen_unit_tb_top.sv
module ea_gen_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  ea_code = '0;
    logic [1:0]  op_size = '0;
    logic        wr_intent = 1'b0;
    logic [31:0] pc_in = '0;
    logic        ext_req;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic [3:0]  rf_base_idx, rf_index_idx, rf_wr_idx, reg_idx;
    logic [31:0] rf_base_data, rf_index_data, rf_wr_data, ea_addr, pc_out;
    logic        rf_we, done, reg_direct, illegal, not_writable;
    logic [4:0]  extra_cycles;

    always #5 clk = ~clk;

    logic [31:0] regs [16];
    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'(i) * 32'h10;
        regs[1]  = 32'h0001_0010;
        regs[2]  = 32'h0000_FFF0;
        regs[8]  = 32'h0000_4000;
        regs[9]  = 32'h0010_0000;
        regs[10] = 32'h0001_0000;
        regs[15] = 32'h0000_2000;
    end
    assign rf_base_data  = regs[rf_base_idx];
    assign rf_index_data = regs[rf_index_idx];

    ea_gen_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ea_code_i(ea_code),
        .op_size_i(op_size), .wr_intent_i(wr_intent), .pc_i(pc_in),
        .ext_req_o(ext_req), .ext_valid_i(ext_valid), .ext_word_i(ext_word),
        .rf_base_idx_o(rf_base_idx), .rf_base_data_i(rf_base_data),
        .rf_index_idx_o(rf_index_idx), .rf_index_data_i(rf_index_data),
        .rf_we_o(rf_we), .rf_wr_idx_o(rf_wr_idx), .rf_wr_data_o(rf_wr_data),
        .done_o(done), .ea_addr_o(ea_addr), .reg_direct_o(reg_direct),
        .reg_idx_o(reg_idx), .extra_cycles_o(extra_cycles), .illegal_o(illegal),
        .not_writable_o(not_writable), .pc_o(pc_out)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        rd;
        logic [3:0]  ridx;
        logic [4:0]  extra;
        logic        ill;
        logic        nw;
        logic        we;
        logic [3:0]  widx;
        logic [31:0] wdata;
        logic [31:0] pc;
        logic [7:0]  lat;
    } exp_t;

    exp_t  sbq [$];
    string tagq [$];
    int    tests = 0, fails = 0, resolved = 0;
    int    cyc = 0, start_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per done pulse
    initial begin : monitor
        exp_t  e;
        string t;
        @(posedge rst_n);
        @(negedge clk);
        chk(done == 1'b0 && ext_req == 1'b0 && rf_we == 1'b0, "R12", "reset idle",
            {29'b0, done, ext_req, rf_we}, 32'h0);
        forever begin
            @(negedge clk);
            if (rf_we && !done) chk(1'b0, "R12", "write outside done", 32'h1, 32'h0);
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R12", "unexpected done", 32'h1, 32'h0);
                end else begin
                    e = sbq.pop_front();
                    t = tagq.pop_front();
                    chk(ea_addr == e.addr, t, "ea_addr", ea_addr, e.addr);
                    chk(reg_direct == e.rd, t, "reg_direct", 32'(reg_direct), 32'(e.rd));
                    if (e.rd) chk(reg_idx == e.ridx, t, "reg_idx", 32'(reg_idx), 32'(e.ridx));
                    chk(extra_cycles == e.extra, t, "extra", 32'(extra_cycles), 32'(e.extra));
                    chk(illegal == e.ill, t, "illegal", 32'(illegal), 32'(e.ill));
                    chk(not_writable == e.nw, t, "not_writable", 32'(not_writable), 32'(e.nw));
                    chk(rf_we == e.we, t, "rf_we", 32'(rf_we), 32'(e.we));
                    if (e.we) begin
                        chk(rf_wr_idx == e.widx, t, "wr_idx", 32'(rf_wr_idx), 32'(e.widx));
                        chk(rf_wr_data == e.wdata, t, "wr_data", rf_wr_data, e.wdata);
                    end
                    chk(pc_out == e.pc, t, "pc", pc_out, e.pc);
                    chk(cyc - start_cyc == int'(e.lat), t, "latency",
                        32'(cyc - start_cyc), 32'(e.lat));
                end
                resolved++;
            end
        end
    end

    // driver: pushes the expectation, starts the unit, serves extension words
    task automatic run_case(input string tag, input logic [5:0] code, input logic [1:0] sz,
                            input bit wi, input logic [31:0] pc, input logic [15:0] w0,
                            input logic [15:0] w1, input int nw, input bit stall,
                            input logic [31:0] exp_addr, input logic [4:0] exp_extra,
                            input bit exp_we, input logic [31:0] exp_wdata);
        exp_t e;
        int   idx;
        int   target;
        bit   presented;
        bit   skipped;
        e.addr  = exp_addr;
        e.rd    = (code < 6'h10);
        e.ridx  = code[3:0];
        e.extra = exp_extra;
        e.ill   = (code >= 6'h3D);
        e.nw    = wi && (code >= 6'h3A) && (code <= 6'h3C);
        e.we    = exp_we;
        e.widx  = {1'b1, code[2:0]};
        e.wdata = exp_wdata;
        e.pc    = pc + 32'(2 * nw);
        e.lat   = 8'(nw + 2 + (stall ? nw : 0));
        sbq.push_back(e);
        tagq.push_back(tag);
        target = resolved + 1;
        @(negedge clk);
        start = 1'b1; ea_code = code; op_size = sz; wr_intent = wi; pc_in = pc;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        idx = 0; presented = 1'b0; skipped = 1'b0;
        while (resolved < target) begin
            if (presented) idx++;
            presented = 1'b0;
            ext_valid = 1'b0;
            if (ext_req) begin
                if (stall && !skipped) begin
                    skipped = 1'b1;
                end else begin
                    ext_valid = 1'b1;
                    ext_word  = (idx == 0) ? w0 : w1;
                    presented = 1'b1;
                    skipped   = 1'b0;
                end
            end
            @(negedge clk);
            #1;
        end
        ext_valid = 1'b0;
    endtask

    localparam logic [1:0] B = 2'd0, W = 2'd1, L = 2'd2;
    localparam logic [31:0] PC0 = 32'h0000_1000;

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 register direct
        run_case("R1", 6'h03, W, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h0, 5'd0, 0, 32'h0);
        run_case("R1", 6'h0C, L, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h0, 5'd0, 0, 32'h0);
        // R2 indirect, post-increment, pre-decrement (costs per R9)
        run_case("R2", 6'h12, W, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h0001_0000, 5'd0, 0, 32'h0);
        run_case("R2", 6'h19, L, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h0010_0000, 5'd0, 1, 32'h0010_0004);
        run_case("R2", 6'h1F, B, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h0000_2000, 5'd0, 1, 32'h0000_2002);
        run_case("R2", 6'h18, B, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h0000_4000, 5'd0, 1, 32'h0000_4001);
        run_case("R2_R9", 6'h22, W, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h0000_FFFE, 5'd6, 1, 32'h0000_FFFE);
        run_case("R2_R9", 6'h27, B, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h0000_1FFE, 5'd6, 1, 32'h0000_1FFE);
        run_case("R2_R9", 6'h21, 2'd3, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h000F_FFFC, 5'd10, 1, 32'h000F_FFFC);
        // R3 displacement on An
        run_case("R3", 6'h2A, W, 0, PC0, 16'hFFF0, 16'h0, 1, 0, 32'h0000_FFF0, 5'd8, 0, 32'h0);
        run_case("R3", 6'h29, L, 0, PC0, 16'h0100, 16'h0, 1, 1, 32'h0010_0100, 5'd12, 0, 32'h0);
        // R4 brief index: word index D2, then long index A0 with stalls (R11)
        run_case("R4", 6'h32, W, 0, PC0, 16'h20FC, 16'h0, 1, 0, 32'h0000_FFEC, 5'd10, 0, 32'h0);
        run_case("R4_R11", 6'h31, L, 0, PC0, 16'h8810, 16'h0, 1, 1, 32'h0010_4010, 5'd14, 0, 32'h0);
        // R5 absolute
        run_case("R5", 6'h38, W, 0, PC0, 16'h8000, 16'h0, 1, 0, 32'hFFFF_8000, 5'd8, 0, 32'h0);
        run_case("R5_R11", 6'h39, L, 0, PC0, 16'h00AB, 16'hCDEF, 2, 1, 32'h00AB_CDEF, 5'd16, 0, 32'h0);
        // R6 PC relative
        run_case("R6", 6'h3A, W, 0, 32'h0180_1000, 16'h0010, 16'h0, 1, 0, 32'hFF80_1010, 5'd8, 0, 32'h0);
        run_case("R6", 6'h3B, L, 0, 32'h0000_3000, 16'h18F0, 16'h0, 1, 0, 32'h0001_3000, 5'd14, 0, 32'h0);
        // R7 immediate
        run_case("R7", 6'h3C, B, 0, PC0, 16'h12F0, 16'h0, 1, 0, 32'hFFFF_FFF0, 5'd4, 0, 32'h0);
        run_case("R7", 6'h3C, W, 0, PC0, 16'h7FFF, 16'h0, 1, 0, 32'h0000_7FFF, 5'd4, 0, 32'h0);
        run_case("R7_R10", 6'h3C, L, 1, PC0, 16'hDEAD, 16'hBEEF, 2, 0, 32'hDEAD_BEEF, 5'd8, 0, 32'h0);
        // R8 illegal codes
        run_case("R8", 6'h3D, W, 0, PC0, 16'h0, 16'h0, 0, 0, 32'h0, 5'd0, 0, 32'h0);
        run_case("R8", 6'h3F, L, 1, PC0, 16'h0, 16'h0, 0, 0, 32'h0, 5'd0, 0, 32'h0);
        // R10 write intent on read-only and on writable modes
        run_case("R10", 6'h3A, W, 1, PC0, 16'hFFFE, 16'h0, 1, 0, 32'h0000_0FFE, 5'd8, 0, 32'h0);
        run_case("R10", 6'h39, W, 1, PC0, 16'h0000, 16'h0040, 2, 0, 32'h0000_0040, 5'd12, 0, 32'h0);
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

endmodule